// File: doc/BRIEF.md
# Exponential Backoff Delay Generator

This block supplies the random wait that a shared-medium transmitter observes before it retries after a collision. A free-running counter advances on a tick input. Because this tick is not tied to the transmit timing, the counter's value at any moment is effectively random. A window register holds a run of ones starting at bit 0, and the length of that run sets how wide the backoff window is. Control logic elsewhere sets the window length directly with a 3-bit select, or doubles the window one step at a time after each further collision.

On a start strobe, the block takes the counter value masked by the window and loads a delay counter with the bitwise inverse of it. The delay counter then counts upward on each delay tick. It flags expiry in the cycle after it wraps to zero, so the wait lasts (counter AND window) + 1 ticks. The delay value can be placed on a read bus for inspection.

Top module: `backoff_gen`

## Requirements
- R1: After reset the read bus shows 0 with read enabled, the done flag is low, the free counter is 0 and the window is 1 (only bit 0 set).
- R2: The free counter adds one on each cycle with `rndTick` high, wraps from 1023 to 0, and holds otherwise.
- R3: With `maskLoad` high and select value s (0..7), the window becomes s+1 low-order ones, and bits 8 and 9 become clear.
- R4: With `maskGrow` high, the window shifts left by one and a 1 is inserted at bit 0. A full window of ten ones stays full.
- R5: With `maskClr` high, the window returns to 1. Bit 0 of the window is never clear.
- R6: Window commands have a fixed priority: clear over load, and load over grow.
- R7: On a cycle with `delayStart` high, the delay counter loads the bitwise NOT of (free counter AND window), using their values before that clock edge. The loaded value shows on the read bus in the next cycle.
- R8: While a delay runs, each `delayTick` adds one. After exactly (counter AND window) + 1 ticks the delay counter wraps to 0, and `delayDone` is high for the one cycle that follows the wrapping edge.
- R9: After expiry the delay counter holds at 0 and ignores `delayTick`, and `delayDone` stays low, until the next start.
- R10: A start in the same cycle as a delay tick loads the new value and ignores the tick. A start during a running delay restarts it.
- R11: With `rdEn` low the read bus is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rndTick | input | 1 | Advances the free-running counter |
| maskClr | input | 1 | Returns the window to length 1 |
| maskLoad | input | 1 | Loads the window length from maskSel |
| maskSel | input | 3 | Window length minus one for a load |
| maskGrow | input | 1 | Lengthens the window by one bit |
| delayStart | input | 1 | Loads the delay counter and starts the wait |
| delayTick | input | 1 | Advances the running delay counter |
| delayDone | output | 1 | One-cycle pulse at delay expiry |
| rdEn | input | 1 | Drives the delay counter onto rdBus |
| rdBus | output | 10 | Delay counter value, or 0 when rdEn is low |

## Verification
The bench reaches the wrap of the free counter from 1023 to 0, where a carry chain that breaks at a group boundary leaves high bits stale and gives a wrong loaded delay. It loads every select value with the counter at all ones. This exposes a length that is off by one, or stray bits 8 and 9, directly on the bus. It collides clear, load and grow in the same cycle, and it pushes the window past ten ones, where a bad priority or a shift without saturation corrupts the window. It counts the ticks to expiry, checks the 1-tick minimum and the quiet state after expiry, and issues a start together with a tick, where an off-by-one, a repeated pulse or a counter that keeps running would be seen.

// File: rtl/backoff_pkg.sv
package backoff_pkg;
  parameter int CNT_W = 10;
  parameter int SEL_W = 3;
  parameter int GRP_W = 3;

  typedef struct packed {
    logic cntInc;
    logic maskClr;
    logic maskLoad;
    logic maskGrow;
    logic dlyLoad;
    logic dlyInc;
  } strobe_t;
endpackage

// File: rtl/backoff_carry.sv
// Synchronous toggle generation with carry terms shared per group of GRP bits.
module backoff_carry #(
  parameter int W   = backoff_pkg::CNT_W,
  parameter int GRP = backoff_pkg::GRP_W
) (
  input  logic [W-1:0] q,
  input  logic         en,
  output logic [W-1:0] tgl,
  output logic         wrapOut
);
  localparam int NG = (W + GRP - 1) / GRP;

  logic [NG-1:0] grpAll;
  logic [NG-1:0] pre;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int LO = g * GRP;
    localparam int HI = (LO + GRP - 1 < W) ? LO + GRP - 1 : W - 1;
    assign grpAll[g] = &q[HI:LO];
    if (g == 0) begin : g_first
      assign pre[g] = en;
    end else begin : g_rest
      assign pre[g] = pre[g-1] & grpAll[g-1];
    end
    for (genvar i = LO; i <= HI; i++) begin : g_bit
      if (i == LO) begin : g_lo
        assign tgl[i] = pre[g];
      end else begin : g_up
        assign tgl[i] = pre[g] & (&q[i-1:LO]);
      end
    end
  end

  assign wrapOut = pre[NG-1] & grpAll[NG-1];
endmodule

// File: rtl/backoff_ctrl.sv
module backoff_ctrl
  import backoff_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    rndTick,
  input  logic    maskClr,
  input  logic    maskLoad,
  input  logic    maskGrow,
  input  logic    delayStart,
  input  logic    delayTick,
  input  logic    dlyAllOnes,
  output strobe_t stb,
  output logic    doneOut
);
  logic runQ;
  logic doneQ;
  logic wrap;

  always_comb begin
    stb          = '0;
    stb.cntInc   = rndTick;
    stb.maskClr  = maskClr;
    stb.maskLoad = maskLoad & ~maskClr;
    stb.maskGrow = maskGrow & ~maskClr & ~maskLoad;
    stb.dlyLoad  = delayStart;
    stb.dlyInc   = delayTick & runQ & ~delayStart;
  end

  assign wrap = stb.dlyInc & dlyAllOnes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= wrap;
      if (stb.dlyLoad) runQ <= 1'b1;
      else if (wrap)   runQ <= 1'b0;
    end
  end

  assign doneOut = doneQ;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> !runQ);
  // R6
  mask_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.maskClr, stb.maskLoad, stb.maskGrow}));
endmodule

// File: rtl/backoff_dpath.sv
module backoff_dpath
  import backoff_pkg::*;
#(
  parameter int W     = CNT_W,
  parameter int SW    = SEL_W,
  parameter int GRP   = GRP_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [SW-1:0] sel,
  output logic [W-1:0]  dly,
  output logic          dlyAllOnes
);
  localparam int MAX_LOAD = 1 << SW;

  logic [W-1:0] cntQ;
  logic [W-1:0] tgl;
  logic         cntWrap;
  logic [W-1:1] maskHiQ;
  logic [W-1:0] mask;
  logic [W-1:0] loadVec;
  logic [W-1:0] dlyQ;

  backoff_carry #(.W(W), .GRP(GRP)) u_carry (
    .q      (cntQ),
    .en     (stb.cntInc),
    .tgl    (tgl),
    .wrapOut(cntWrap)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntQ <= '0;
    else       cntQ <= cntQ ^ tgl;
  end

  // Window bit 0 is fixed at one and has no storage.
  assign mask = {maskHiQ, 1'b1};

  for (genvar i = 0; i < W; i++) begin : g_load
    if (i == 0) begin : g_b0
      assign loadVec[i] = 1'b1;
    end else if (i < MAX_LOAD) begin : g_sel
      assign loadVec[i] = ((SW+1)'(i) <= {1'b0, sel});
    end else begin : g_hi
      assign loadVec[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             maskHiQ <= '0;
    else if (stb.maskClr)  maskHiQ <= '0;
    else if (stb.maskLoad) maskHiQ <= loadVec[W-1:1];
    else if (stb.maskGrow) maskHiQ <= mask[W-2:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dlyQ <= '0;
    else if (stb.dlyLoad) dlyQ <= ~(cntQ & mask);
    else if (stb.dlyInc)  dlyQ <= dlyQ + 1'b1;
  end

  assign dly        = dlyQ;
  assign dlyAllOnes = &dlyQ;

  // R2
  cnt_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.cntInc |=> cntQ == W'($past(cntQ) + 1'b1));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.cntInc |=> $stable(cntQ));
  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntWrap |=> cntQ == '0);
  // R5
  mask_thermo_chk: assert property (@(posedge clk) disable iff (!rstN)
    mask[0] && (((mask + 1'b1) & mask) == '0));
  // R4
  mask_grow_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.maskGrow |=> mask == {$past(mask[W-2:0]), 1'b1});
  // R9
  dly_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.dlyLoad && !stb.dlyInc) |=> $stable(dlyQ));
endmodule

// File: rtl/backoff_gen.sv
module backoff_gen (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rndTick,
  input  logic       maskClr,
  input  logic       maskLoad,
  input  logic [2:0] maskSel,
  input  logic       maskGrow,
  input  logic       delayStart,
  input  logic       delayTick,
  output logic       delayDone,
  input  logic       rdEn,
  output logic [9:0] rdBus
);
  import backoff_pkg::*;

  strobe_t    stb;
  logic [9:0] dly;
  logic       dlyAllOnes;

  backoff_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rndTick   (rndTick),
    .maskClr   (maskClr),
    .maskLoad  (maskLoad),
    .maskGrow  (maskGrow),
    .delayStart(delayStart),
    .delayTick (delayTick),
    .dlyAllOnes(dlyAllOnes),
    .stb       (stb),
    .doneOut   (delayDone)
  );

  backoff_dpath #(.W(10), .SW(3), .GRP(3)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .sel       (maskSel),
    .dly       (dly),
    .dlyAllOnes(dlyAllOnes)
  );

  assign rdBus = rdEn ? dly : '0;

  // R11
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> rdBus == '0);
endmodule

// File: tb/backoff_gen_bench.sv
`timescale 1ns/1ps
module backoff_gen_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rndTick = 0, maskClr = 0, maskLoad = 0, maskGrow = 0;
  logic [2:0] maskSel = 0;
  logic delayStart = 0, delayTick = 0, rdEn = 1;
  logic delayDone;
  logic [9:0] rdBus;

  int nRun = 0;
  int nFail = 0;
  int cyc = 0;
  logic [9:0] cntM = 0, maskM = 10'd1, dlyM = 0;
  logic runM = 0, doneM = 0;

  always #2 clk = ~clk;

  backoff_gen u_backoff_gen (.*);

  function automatic logic [9:0] loadMask(input logic [2:0] s);
    return 10'((11'd1 << (s + 1)) - 1);
  endfunction

  function automatic logic [9:0] nextMask(input logic [9:0] m, input logic c,
      input logic l, input logic [2:0] s, input logic g);
    if (c) return 10'd1;
    if (l) return loadMask(s);
    if (g) return {m[8:0], 1'b1};
    return m;
  endfunction

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Applies one cycle of stimulus at a negedge, updates the model, checks outputs.
  task automatic step(input string tag, input logic t, input logic c, input logic l,
      input logic [2:0] s, input logic g, input logic st, input logic dt);
    logic inc, wrp;
    rndTick = t; maskClr = c; maskLoad = l; maskSel = s; maskGrow = g;
    delayStart = st; delayTick = dt;
    @(posedge clk);
    inc = dt & runM & ~st;
    wrp = inc & (dlyM == 10'h3FF);
    if (st) dlyM = ~(cntM & maskM);
    else if (inc) dlyM = dlyM + 1'b1;
    if (st) runM = 1'b1; else if (wrp) runM = 1'b0;
    doneM = wrp;
    maskM = nextMask(maskM, c, l, s, g);
    if (t) cntM = cntM + 1'b1;
    @(negedge clk);
    rndTick = 0; maskClr = 0; maskLoad = 0; maskGrow = 0; delayStart = 0; delayTick = 0;
    chk({tag, " bus"}, rdBus, rdEn ? dlyM : 10'h000);
    chk({tag, " done"}, {9'd0, delayDone}, {9'd0, doneM});
  endtask

  task automatic tickTo(input logic [9:0] target);
    while (cntM != target) step("R2", 1, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nFail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", nRun, nFail);
        $finish;
      end
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 bus", rdBus, 10'h000);
    chk("R1 done", {9'd0, delayDone}, 10'h000);
    rstN = 1'b1;
    @(negedge clk);
    step("R1", 1, 0, 0, 0, 0, 0, 0);
    step("R1", 0, 0, 0, 0, 0, 1, 0);
    chk("R1 window one", rdBus, 10'h3FE);

    // R2: counter reaches all ones, then wraps
    tickTo(10'h3FF);
    step("R2", 0, 0, 1, 3'd7, 0, 1, 0);
    step("R2", 0, 0, 0, 0, 0, 1, 0);
    chk("R2 counter at 1023", rdBus, 10'h300);
    step("R2", 1, 0, 0, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 1, 0);
    chk("R2 counter wrapped", rdBus, 10'h3FF);
    tickTo(10'h3FF);

    // R3: every select value with the counter at all ones
    for (int s = 0; s < 8; s++) begin
      step("R3", 0, 0, 1, 3'(s), 0, 0, 0);
      step("R3", 0, 0, 0, 0, 0, 1, 0);
      chk("R3 load length", rdBus, ~loadMask(3'(s)));
    end

    // R4: grow past eight to ten, then saturate
    step("R4", 0, 0, 0, 0, 1, 0, 0);
    step("R4", 0, 0, 0, 0, 1, 0, 0);
    step("R4", 0, 0, 0, 0, 0, 1, 0);
    chk("R4 ten ones", rdBus, 10'h000);
    step("R4", 0, 0, 0, 0, 1, 1, 0);
    step("R4", 0, 0, 0, 0, 0, 1, 0);
    chk("R4 saturated", rdBus, 10'h000);

    // R5: clear back to one bit
    step("R5", 0, 1, 0, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 1, 0);
    chk("R5 cleared", rdBus, 10'h3FE);

    // R6: priorities
    step("R6", 0, 1, 1, 3'd5, 1, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 1, 0);
    chk("R6 clear wins", rdBus, 10'h3FE);
    step("R6", 0, 0, 1, 3'd2, 1, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 1, 0);
    chk("R6 load wins", rdBus, 10'h3F8);

    // R7 and R8: counter 5, window 3 bits -> 6 ticks
    tickTo(10'd5);
    step("R7", 0, 0, 0, 0, 0, 1, 0);
    chk("R7 loaded", rdBus, ~10'd5);
    begin
      int n = 0;
      while (!delayDone && n < 20) begin
        step("R8", 0, 0, 0, 0, 0, 0, 1);
        n++;
      end
      chk("R8 tick count", 10'(n), 10'd6);
    end
    // R9: ticks after expiry are ignored
    step("R9", 0, 0, 0, 0, 0, 0, 1);
    step("R9", 0, 0, 0, 0, 0, 0, 1);
    chk("R9 held zero", rdBus, 10'h000);
    chk("R9 done low", {9'd0, delayDone}, 10'h000);

    // R8: minimum one tick when masked value is zero
    tickTo(10'd8);
    step("R8", 0, 0, 0, 0, 0, 1, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 1);
    chk("R8 one tick", {9'd0, delayDone}, 10'h001);

    // R10: start with tick, then restart mid-count
    step("R10", 0, 0, 0, 0, 1, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 1, 1);
    chk("R10 tick ignored", rdBus, ~10'd8);
    step("R10", 0, 0, 0, 0, 0, 0, 1);
    step("R10", 1, 0, 0, 0, 0, 1, 0);
    chk("R10 restart", rdBus, ~10'd8);

    // R11: read gate
    rdEn = 1'b0;
    step("R11", 0, 0, 0, 0, 0, 0, 1);
    chk("R11 bus gated", rdBus, 10'h000);
    rdEn = 1'b1;

    // Random mix for R7 and R8
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] r;
      r = 4'($urandom_range(0, 15));
      step("R7/R8", $urandom_range(0, 1) == 1, r == 0, r == 1, 3'($urandom_range(0, 7)),
           r == 2, r == 3 || (r == 4 && !runM), $urandom_range(0, 3) != 0);
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule